// File: doc/BRIEF.md
# Framed 16-bit Converter Word Receiver

This block is the serial input side of a 12-bit digital-to-analog converter. A host drives four lines into it: a serial clock, a serial data line, a frame-sync strobe and an active-low chip select. A rising edge on frame sync opens a word. The next sixteen falling edges of the serial clock shift in sixteen data bits, most significant bit first. When the sixteenth bit has arrived, the word is decoded into a 12-bit converter code, a fast-settling select and a power-down flag. These three outputs are registered and stay unchanged until the next complete word.

The block never drives data back to the host. Every serial line is brought into the block's own clock domain through a parameterised synchroniser, and edges are detected in that domain. When chip select is high the port is detached: clock edges, data and frame-sync strobes have no effect, and any partial word stays as it was. Word length, code width and synchroniser depth are parameters. The mode bits always sit at fixed offsets below the top of the word.

Top module: `dac_word_rx`

## Requirements
- R1: After reset, `dac_code` is 0, `fast_settle` is 0 (slow) and `power_down` is 0.
- R2: A word is 16 bits, taken most significant bit first on falling edges of `sclk` after a rising edge of `fsync`. The bit sampled in each case is the level of `sdin` at that edge. Word bits 11..0 appear on `dac_code`.
- R3: Word bit 14 drives `fast_settle` (1 = fast, 0 = slow). Word bit 13 drives `power_down` (1 = powered down, 0 = normal). Word bits 15 and 12 change no output.
- R4: `dac_code`, `fast_settle` and `power_down` change together. They change only after the 16th bit of a frame has been sampled, and otherwise hold their value.
- R5: A rising edge of `fsync` before the 16th bit throws away the partial word, and the following bits start a fresh 16-bit count.
- R6: Once 16 bits have been taken, further `sclk` edges and `sdin` values are ignored until the next rising edge of `fsync`.
- R7: While `cs_n` is high, `sclk` edges, `sdin` and `fsync` edges are ignored. A partial word taken before `cs_n` rose continues when `cs_n` returns low.
- R8: The outputs show a completed word no more than SYNC_STAGES+3 `clk` cycles after the falling `sclk` edge of its 16th bit. Each level of `sclk`, `fsync` and `cs_n` must be held for at least two `clk` cycles. `sdin` must be stable from before the falling `sclk` edge until after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data are taken on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| fsync | input | 1 | Frame-sync strobe; a rising edge opens a word |
| cs_n | input | 1 | Active-low chip select; high detaches the port |
| dac_code | output | 12 | Converter code from word bits 11..0 |
| fast_settle | output | 1 | Settling-speed select from word bit 14 |
| power_down | output | 1 | Power-down flag from word bit 13 |

## Verification
A bit counter that is off by one shows up as a shifted or rotated code and as mode flags taken from the wrong positions. This is visible on the outputs within SYNC_STAGES+3 cycles of the edge that should have finished the word. Two other faults show up a word early or never: a counter that restart or chip select fails to freeze or clear, and a completion that fires on the 15th bit. The sweep covers every top-nibble value and every single code bit, so a swapped or misplaced field is exposed on the first word that sets it.

// File: rtl/dac_word_rx_pkg.sv
package dac_word_rx_pkg;

   typedef enum logic {
      FR_IDLE = 1'b0,
      FR_RECV = 1'b1
   } frame_st_e;

   localparam int DEF_WORD_W = 16;
   localparam int DEF_CODE_W = 12;

endpackage

// File: rtl/dwr_sync.sv
module dwr_sync #(
   parameter int             WIDTH   = 4,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 0) begin : g_bad_depth
         $error("dwr_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stg[i] <= RST_VAL;
               end else begin
                  if (i == 0) begin
                     stg[i] <= d;
                  end else begin
                     stg[i] <= stg[(i == 0) ? 0 : i-1];
                  end
               end
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dwr_edge.sv
module dwr_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_s,
   input  logic fsync_s,
   output logic sclk_fall,
   output logic fsync_rise
);

   logic sclk_d;
   logic fsync_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         fsync_d <= 1'b0;
      end else begin
         sclk_d  <= sclk_s;
         fsync_d <= fsync_s;
      end
   end

   assign sclk_fall  = sclk_d & ~sclk_s;
   assign fsync_rise = fsync_s & ~fsync_d;

endmodule

// File: rtl/dwr_shift.sv
module dwr_shift
   import dac_word_rx_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CNT_W  = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              bit_stb,
   input  logic              din,
   output logic [WORD_W-1:0] word,
   output logic              word_done,
   output logic [CNT_W-1:0]  bit_cnt
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   frame_st_e        st;
   logic [WORD_W-1:0] shreg;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("dwr_shift: WORD_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= FR_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         word_done <= 1'b0;
      end else begin
         word_done <= 1'b0;
         if (restart) begin
            st      <= FR_RECV;
            bit_cnt <= '0;
         end else if (bit_stb && (st == FR_RECV)) begin
            shreg   <= {shreg[WORD_W-2:0], din};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
               st        <= FR_IDLE;
               word_done <= 1'b1;
            end
         end
      end
   end

   assign word = shreg;

endmodule

// File: rtl/dwr_decode.sv
module dwr_decode #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] code_in,
   input  logic              fast_in,
   input  logic              pd_in,
   output logic [CODE_W-1:0] code_q,
   output logic              fast_q,
   output logic              pd_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         fast_q <= 1'b0;
         pd_q   <= 1'b0;
      end else if (load) begin
         code_q <= code_in;
         fast_q <= fast_in;
         pd_q   <= pd_in;
      end
   end

endmodule

// File: rtl/dac_word_rx.sv
module dac_word_rx #(
   parameter int WORD_W      = 16,
   parameter int CODE_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              sdin,
   input  logic              fsync,
   input  logic              cs_n,
   output logic [CODE_W-1:0] dac_code,
   output logic              fast_settle,
   output logic              power_down
);

   localparam int FAST_POS = WORD_W - 2;
   localparam int PD_POS   = WORD_W - 3;
   localparam int CNT_W    = $clog2(WORD_W + 1);
   localparam int N_LINES  = 4;

   generate
      if (PD_POS < CODE_W) begin : g_bad_layout
         $error("dac_word_rx: WORD_W must leave three mode bits above CODE_W");
      end
      if (CODE_W < 1) begin : g_bad_code
         $error("dac_word_rx: CODE_W must be positive");
      end
   endgenerate

   logic [N_LINES-1:0] lines_s;
   logic               sclk_s;
   logic               sdin_s;
   logic               fsync_s;
   logic               cs_s;
   logic               sclk_fall;
   logic               fsync_rise;
   logic               bit_stb;
   logic               restart;
   logic [WORD_W-1:0]  word;
   logic               word_done;
   logic [CNT_W-1:0]   bit_cnt;

   dwr_sync #(
      .WIDTH   (N_LINES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b1000)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, fsync, sdin, sclk}),
      .q     (lines_s)
   );

   assign sclk_s  = lines_s[0];
   assign sdin_s  = lines_s[1];
   assign fsync_s = lines_s[2];
   assign cs_s    = lines_s[3];

   dwr_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_s     (sclk_s),
      .fsync_s    (fsync_s),
      .sclk_fall  (sclk_fall),
      .fsync_rise (fsync_rise)
   );

   assign bit_stb = sclk_fall & ~cs_s;
   assign restart = fsync_rise & ~cs_s;

   dwr_shift #(
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .bit_stb   (bit_stb),
      .din       (sdin_s),
      .word      (word),
      .word_done (word_done),
      .bit_cnt   (bit_cnt)
   );

   dwr_decode #(
      .CODE_W (CODE_W)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (word_done),
      .code_in (word[CODE_W-1:0]),
      .fast_in (word[FAST_POS]),
      .pd_in   (word[PD_POS]),
      .code_q  (dac_code),
      .fast_q  (fast_settle),
      .pd_q    (power_down)
   );

endmodule

// File: rtl/dwr_chk.sv
module dwr_chk #(
   parameter int WORD_W   = 16,
   parameter int CODE_W   = 12,
   parameter int FAST_POS = 14,
   parameter int PD_POS   = 13,
   parameter int CNT_W    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_s,
   input logic              restart,
   input logic              word_done,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic [WORD_W-1:0] word,
   input logic [CODE_W-1:0] dac_code,
   input logic              fast_settle,
   input logic              power_down
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

   // R1: outputs are cleared when reset lifts
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dac_code == '0 && !fast_settle && !power_down));

   // R2 / R3: a completed word lands on all three outputs on the next cycle
   a_r2_word_load: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> (dac_code == $past(word[CODE_W-1:0]) &&
                     fast_settle == $past(word[FAST_POS]) &&
                     power_down == $past(word[PD_POS])));

   // R4: without a completion the outputs hold
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !word_done |=> $stable({dac_code, fast_settle, power_down}));

   // R4: the bit counter never runs past one word
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= FULL);

   // R5: a frame restart clears the count
   a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (bit_cnt == '0));

   // R6: a full word is frozen until the next frame
   a_r6_tail_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt == FULL && !restart) |=> ($stable(word) && bit_cnt == FULL));

   // R7: deselected port does not advance
   a_r7_detached: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> ($stable(bit_cnt) && $stable(word)));

endmodule

bind dac_word_rx dwr_chk #(
   .WORD_W   (WORD_W),
   .CODE_W   (CODE_W),
   .FAST_POS (FAST_POS),
   .PD_POS   (PD_POS),
   .CNT_W    (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_s        (cs_s),
   .restart     (restart),
   .word_done   (word_done),
   .bit_cnt     (bit_cnt),
   .word        (word),
   .dac_code    (dac_code),
   .fast_settle (fast_settle),
   .power_down  (power_down)
);

// File: tb/dac_word_rx_tb.sv
module dac_word_rx_tb;

   localparam int HALF   = 4;
   localparam int SETTLE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        sdin = 1'b0;
   logic        fsync = 1'b0;
   logic        cs_n = 1'b0;
   logic [11:0] dac_code;
   logic        fast_settle;
   logic        power_down;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dac_word_rx u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk        (sclk),
      .sdin        (sdin),
      .fsync       (fsync),
      .cs_n        (cs_n),
      .dac_code    (dac_code),
      .fast_settle (fast_settle),
      .power_down  (power_down)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      sdin = b;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic send_range(input logic [15:0] w, input int hi, input int lo);
      for (int i = hi; i >= lo; i--) send_bit(w[i]);
   endtask

   task automatic frame_pulse();
      fsync = 1'b1;
      wait_clk(3);
      fsync = 1'b0;
      wait_clk(3);
   endtask

   task automatic send_word(input logic [15:0] w);
      frame_pulse();
      send_range(w, 15, 0);
      wait_clk(SETTLE);
   endtask

   // expected output packing: {fast, power-down, code}
   function automatic logic [13:0] expect_of(input logic [15:0] w);
      return {w[14], w[13], w[11:0]};
   endfunction

   task automatic chk(input string req, input logic [13:0] exp_v);
      logic [13:0] act;
      act = {fast_settle, power_down, dac_code};
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R8 watchdog actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      logic [15:0] w;
      logic [15:0] prev;
      wait_clk(4);
      // R1: reset state
      chk("R1", 14'h0);
      rst_n = 1'b1;
      wait_clk(4);
      chk("R1", 14'h0);

      // R2: walking one across each code bit, top nibble zero
      for (int b = 0; b < 12; b++) begin
         w = 16'(1 << b);
         send_word(w);
         chk("R2", expect_of(w));
      end

      // R3: every top-nibble value with an arithmetic code
      for (int n = 0; n < 16; n++) begin
         w = {4'(n), 12'((n * 273 + 5) % 4096)};
         send_word(w);
         chk("R3", expect_of(w));
      end

      // R2 / R8: alternating pattern, checked at the latency bound
      w = 16'h6A5C;
      frame_pulse();
      send_range(w, 15, 1);
      sdin = w[0];
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
      wait_clk(5);
      chk("R8", expect_of(w));
      wait_clk(HALF);
      prev = w;

      // R4: nothing moves after 15 bits, then all three together
      w = 16'h1F3E;
      frame_pulse();
      send_range(w, 15, 1);
      wait_clk(SETTLE);
      chk("R4", expect_of(prev));
      send_bit(w[0]);
      wait_clk(SETTLE);
      chk("R4", expect_of(w));
      prev = w;

      // R5: partial word dropped on a new frame
      frame_pulse();
      send_range(16'hFFFF, 15, 9);
      w = 16'h2481;
      send_word(w);
      chk("R5", expect_of(w));
      prev = w;

      // R6: bits after the 16th are ignored
      send_range(16'hDBCA, 15, 0);
      wait_clk(SETTLE);
      chk("R6", expect_of(prev));
      send_range(16'hFFFF, 15, 12);
      wait_clk(SETTLE);
      chk("R6", expect_of(prev));

      // R7: deselect mid-word, junk edges and a frame pulse are ignored
      w = 16'h4C37;
      frame_pulse();
      send_range(w, 15, 8);
      cs_n = 1'b1;
      wait_clk(4);
      frame_pulse();
      send_range(16'hFFFF, 15, 10);
      wait_clk(SETTLE);
      chk("R7", expect_of(prev));
      cs_n = 1'b0;
      wait_clk(4);
      send_range(w, 7, 0);
      wait_clk(SETTLE);
      chk("R7", expect_of(w));
      prev = w;

      // R7: a whole framed word while deselected changes nothing
      cs_n = 1'b1;
      wait_clk(4);
      send_word(16'hFFFF);
      chk("R7", expect_of(prev));
      cs_n = 1'b0;
      wait_clk(4);

      // R3: don't-care bits alone change nothing
      w = {1'b1, prev[14:13], 1'b1, prev[11:0]};
      send_word(w);
      chk("R3", expect_of(prev));

      finished = 1'b1;
      finish_run();
   end

endmodule